// File: doc/BRIEF.md
# CAN Transmit Dominant Timeout Guard

This block sits between the transmit output of a CAN protocol controller and the enable of the bus driver. The transmit line is active low: a low level is dominant and a high level is recessive. The block measures how long that line stays dominant. If it stays low for too long, the block turns the driver off so that the bus goes back to recessive. A node that has failed in this way therefore cannot hold the bus dominant and block all other traffic.

The transmit line and the standby select are first passed through a two-flop synchronizer. Edges are found by comparing each synchronized sample with the one before it. A falling edge starts a saturating cycle counter. Once the counter reaches the timeout limit, the block raises a one-cycle pulse and a sticky status flag, and it keeps the driver off. The driver stays off until a rising edge on the transmit line clears the timer and the flag; it never recovers by itself.

While standby is selected, the driver is off whatever the transmit level, but the timer keeps watching the line. The timeout length is a parameter in clock cycles. Its default gives 2 ms at a 250 MHz clock, which stays well above the 300 µs floor that bit rates down to 40 kbit/s need.

Top module: `can_dom_guard`

## Requirements
- R1: While reset is asserted, and for the two clock edges after it is released, `drv_en` is 0, `txd_gated` is 1 and both `tmo_pulse` and `tmo_flag` are 0. An input that reads high counts as recessive.
- R2: While the driver is enabled, `txd_gated` follows `txd_in` two clock edges later (low = dominant, high = recessive). Whenever `drv_en` is 0, `txd_gated` is 1.
- R3: If `txd_in` is held low for exactly `TIMEOUT_CYC` sampled cycles after a high level, the driver is disabled: `drv_en` goes to 0 and `txd_gated` to 1.
- R4: A dominant period of `TIMEOUT_CYC-1` sampled cycles does not trip the timer, and traffic passes unchanged.
- R5: At the trip, `tmo_pulse` is 1 for exactly one cycle.
- R6: `tmo_flag` rises with the pulse and holds until a rising edge on `txd_in`. It clears three clock edges after `txd_in` goes high, and the driver is re-enabled in that same cycle.
- R7: While `txd_in` stays low after a trip, the driver stays off and no further pulse appears, however long the low lasts (the counter saturates).
- R8: With `stby_in` = 1 (standby), `drv_en` is 0 and `txd_gated` is 1 whatever `txd_in` does. The timer still runs. With `stby_in` = 0 (normal), the guard acts as above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| txd_in | input | 1 | Transmit level from the protocol controller (0 = dominant) |
| stby_in | input | 1 | 1 = standby (driver off), 0 = normal operation |
| drv_en | output | 1 | Bus driver enable |
| txd_gated | output | 1 | Transmit level to the driver, forced recessive while disabled |
| tmo_pulse | output | 1 | One-cycle pulse when the timeout trips |
| tmo_flag | output | 1 | Sticky timeout status, cleared by the next rising transmit edge |

## Verification
Each result has a fixed latency:
- A level on `txd_in` reaches `txd_gated` two edges after it is sampled.
- The trip lands on the edge at which the low level has been sampled `TIMEOUT_CYC` times.
- The flag clears, and the driver comes back, three edges after the line returns high.
- Outputs leave reset two edges after `rst_n` rises.

The bench steps a behavioural cycle model on each rising edge, using the same inputs the design sees. It compares all four outputs against that model on every falling edge. Inputs change just after a falling edge, so neither side races the other. Point checks then pin the boundary lengths `TIMEOUT_CYC-1` and `TIMEOUT_CYC`, the pulse count over a long low, and standby.

// File: rtl/cdg_pkg.sv
package cdg_pkg;
  typedef enum logic [1:0] {
    TMR_IDLE = 2'd0,
    TMR_RUN  = 2'd1,
    TMR_TRIP = 2'd2
  } tmr_state_e;
endpackage

// File: rtl/cdg_sync.sv
// Multi-bit flop chain with per-bit asynchronous reset value.
module cdg_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_comb stage_d[g] = d_in;
    end else begin : g_rest
      always_comb stage_d[g] = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= RST_VAL;
      else        stage_q[g] <= stage_d[g];
    end
  end

  assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/cdg_edge.sv
// Edge finder on a synchronized level; idle level is recessive (high).
module cdg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  output logic fall_o,
  output logic rise_o
);
  logic prev_q;
  logic prev_d;

  always_comb prev_d = lvl_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= prev_d;
  end

  assign fall_o = prev_q & ~lvl_in;
  assign rise_o = ~prev_q & lvl_in;
endmodule

// File: rtl/cdg_timer.sv
// Dominant-length timer: starts on fall, saturates at LIMIT, cleared by rise.
module cdg_timer
  import cdg_pkg::*;
#(
  parameter int LIMIT = 500_000,
  parameter int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_i,
  input  logic rise_i,
  output logic tripped_o,
  output logic pulse_o,
  output logic flag_o
);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

  tmr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             pulse_q, pulse_d;
  logic             flag_q, flag_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    flag_d  = flag_q;
    cnt_en  = 1'b0;
    if (rise_i) begin
      state_d = TMR_IDLE;
      cnt_d   = '0;
      flag_d  = 1'b0;
      cnt_en  = 1'b1;
    end else if (fall_i || state_q == TMR_RUN) begin
      cnt_en = 1'b1;
      cnt_d  = fall_i ? ONE_V : cnt_q + ONE_V;
      if (cnt_d == LIM_V) begin
        state_d = TMR_TRIP;
        pulse_d = 1'b1;
        flag_d  = 1'b1;
      end else begin
        state_d = TMR_RUN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TMR_IDLE;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      pulse_q <= pulse_d;
      flag_q  <= flag_d;
    end
  end

  assign tripped_o = (state_q == TMR_TRIP);
  assign pulse_o   = pulse_q;
  assign flag_o    = flag_q;
endmodule

// File: rtl/cdg_outgate.sv
// Driver enable and recessive forcing.
module cdg_outgate (
  input  logic txd_s,
  input  logic stby_s,
  input  logic tripped,
  output logic drv_en,
  output logic txd_gated
);
  always_comb begin
    drv_en    = ~stby_s & ~tripped;
    txd_gated = drv_en ? txd_s : 1'b1;
  end
endmodule

// File: rtl/can_dom_guard.sv
module can_dom_guard #(
  parameter int TIMEOUT_CYC = 500_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_in,
  input  logic stby_in,
  output logic drv_en,
  output logic txd_gated,
  output logic tmo_pulse,
  output logic tmo_flag
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

  logic       rst_sync_n;
  logic [1:0] raw_in, syn_out;
  logic       fall_w, rise_w, tripped_w;

  // Reset: asserted at once, released after two edges.
  cdg_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst (
    .clk(clk), .rst_n(rst_n), .d_in(1'b1), .q_out(rst_sync_n)
  );

  // Bit 1 = standby select, bit 0 = transmit; both idle high.
  assign raw_in = {stby_in, txd_in};
  cdg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_in(raw_in), .q_out(syn_out)
  );

  cdg_edge u_edge (
    .clk(clk), .rst_n(rst_sync_n), .lvl_in(syn_out[0]),
    .fall_o(fall_w), .rise_o(rise_w)
  );

  cdg_timer #(.LIMIT(TIMEOUT_CYC), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .fall_i(fall_w), .rise_i(rise_w),
    .tripped_o(tripped_w), .pulse_o(tmo_pulse), .flag_o(tmo_flag)
  );

  cdg_outgate u_gate (
    .txd_s(syn_out[0]), .stby_s(syn_out[1]), .tripped(tripped_w),
    .drv_en(drv_en), .txd_gated(txd_gated)
  );
endmodule

// File: rtl/cdg_guard_chk.sv
module cdg_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic txd_in,
  input logic stby_in,
  input logic drv_en,
  input logic txd_gated,
  input logic tmo_pulse,
  input logic tmo_flag
);
  AST_GATED_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> txd_gated); // R2
  AST_FLAG_DRIVER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag |-> !drv_en); // R3
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |=> !tmo_pulse); // R5
  AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |-> tmo_flag); // R6
  AST_FLAG_CLEAR_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tmo_flag) |-> $past(txd_in, 3)); // R6
  AST_NO_SECOND_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && $past(tmo_flag)) |-> !tmo_pulse); // R7
  AST_STANDBY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_in && $past(stby_in) && $past(stby_in, 2)) |-> !drv_en); // R8
endmodule

bind can_dom_guard cdg_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd_in(txd_in), .stby_in(stby_in),
  .drv_en(drv_en), .txd_gated(txd_gated), .tmo_pulse(tmo_pulse), .tmo_flag(tmo_flag)
);

// File: tb/test_can_dom_guard.sv
`timescale 1ns/1ps
module test_can_dom_guard;
  localparam int L = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd_in = 1'b1;
  logic stby_in = 1'b0;
  logic drv_en, txd_gated, tmo_pulse, tmo_flag;

  int n_chk = 0;
  int n_fail = 0;
  int n_pulse = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  can_dom_guard #(.TIMEOUT_CYC(L)) i_can_dom_guard (
    .clk(clk), .rst_n(rst_n), .txd_in(txd_in), .stby_in(stby_in),
    .drv_en(drv_en), .txd_gated(txd_gated), .tmo_pulse(tmo_pulse), .tmo_flag(tmo_flag)
  );

  // Behavioural cycle model
  int rel = 0;
  int m_cnt = 0;
  bit m_run = 0, m_trip = 0, m_flag = 0, m_pulse = 0;
  bit m_s = 1, m_s1 = 1, m_prev = 1, m_st = 1, m_st1 = 1;

  task automatic m_clear();
    m_s = 1; m_s1 = 1; m_prev = 1; m_st = 1; m_st1 = 1;
    m_cnt = 0; m_run = 0; m_trip = 0; m_flag = 0; m_pulse = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel = 0; m_clear();
    end else if (rel < 2) begin
      rel++; m_clear();
    end else begin
      bit f, r;
      f = m_prev && !m_s;
      r = !m_prev && m_s;
      m_pulse = 0;
      if (r) begin
        m_cnt = 0; m_run = 0; m_trip = 0; m_flag = 0;
      end else if (f || (m_run && !m_trip)) begin
        m_cnt = f ? 1 : m_cnt + 1;
        m_run = 1;
        if (m_cnt == L) begin m_trip = 1; m_flag = 1; m_pulse = 1; end
      end
      m_prev = m_s; m_s = m_s1; m_s1 = txd_in;
      m_st = m_st1; m_st1 = stby_in;
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      logic e_en, e_gt;
      e_en = !m_st && !m_trip;
      e_gt = e_en ? m_s : 1'b1;
      check(cur_req, "drv_en", drv_en, e_en);
      check(cur_req, "txd_gated", txd_gated, e_gt);
      check(cur_req, "tmo_pulse", tmo_pulse, m_pulse);
      check(cur_req, "tmo_flag", tmo_flag, m_flag);
      if (tmo_pulse === 1'b1) n_pulse++;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic low_for(input int n);
    txd_in = 1'b0; wait_cyc(n); txd_in = 1'b1;
  endtask

  initial begin
    fork
      begin : main_seq
        int p0;
        // R1: reset state
        cur_req = "R1";
        wait_cyc(4);
        check("R1", "drv_en in reset", drv_en, 1'b0);
        check("R1", "txd_gated in reset", txd_gated, 1'b1);
        rst_n = 1'b1;
        wait_cyc(1);
        check("R1", "drv_en just after release", drv_en, 1'b0);
        wait_cyc(4);
        check("R1", "drv_en after release", drv_en, 1'b1);

        // R2: pass-through pattern
        cur_req = "R2";
        txd_in = 0; wait_cyc(1); txd_in = 1; wait_cyc(2); txd_in = 0; wait_cyc(3);
        txd_in = 1; wait_cyc(1); txd_in = 0; wait_cyc(2);
        check("R2", "txd_gated low follows", txd_gated, 1'b0);
        txd_in = 1; wait_cyc(5);
        check("R2", "txd_gated idle", txd_gated, 1'b1);

        // R4: one cycle short of the limit
        cur_req = "R4";
        p0 = n_pulse;
        low_for(L - 1); wait_cyc(6);
        check("R4", "pulses at L-1", 1'(n_pulse - p0 != 0), 1'b0);
        check("R4", "drv_en after L-1", drv_en, 1'b1);

        // R3/R5/R6: exactly the limit
        cur_req = "R3";
        p0 = n_pulse;
        txd_in = 0; wait_cyc(L + 3);
        check("R3", "drv_en after L", drv_en, 1'b0);
        check("R3", "txd_gated after L", txd_gated, 1'b1);
        check("R5", "single pulse", 1'(n_pulse - p0 == 1), 1'b1);
        check("R6", "flag held", tmo_flag, 1'b1);
        cur_req = "R6";
        txd_in = 1; wait_cyc(2);
        check("R6", "flag before clear", tmo_flag, 1'b1);
        wait_cyc(1);
        check("R6", "flag cleared", tmo_flag, 1'b0);
        check("R6", "driver back", drv_en, 1'b1);
        wait_cyc(4);

        // R7: long low, no self-recovery, no repeat pulse
        cur_req = "R7";
        p0 = n_pulse;
        txd_in = 0; wait_cyc(3 * L + 5);
        check("R7", "drv_en stays off", drv_en, 1'b0);
        check("R7", "one pulse only", 1'(n_pulse - p0 == 1), 1'b1);
        txd_in = 1; wait_cyc(6);

        // R8: standby
        cur_req = "R8";
        stby_in = 1; wait_cyc(3);
        txd_in = 0; wait_cyc(4);
        check("R8", "drv_en in standby", drv_en, 1'b0);
        check("R8", "txd_gated in standby", txd_gated, 1'b1);
        wait_cyc(L);
        check("R8", "timer runs in standby", tmo_flag, 1'b1);
        txd_in = 1; wait_cyc(5);
        stby_in = 0; wait_cyc(4);
        check("R8", "normal after standby", drv_en, 1'b1);

        // R1: reset while tripped
        cur_req = "R1";
        txd_in = 0; wait_cyc(L + 4);
        rst_n = 0; wait_cyc(2);
        check("R1", "flag in reset", tmo_flag, 1'b0);
        check("R1", "drv_en in mid reset", drv_en, 1'b0);
        txd_in = 1; rst_n = 1; wait_cyc(6);
        check("R1", "drv_en after reset", drv_en, 1'b1);
      end
      begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule